// File: doc/BRIEF.md
# Two-Word Accumulator Processor with Shared Memory

This block is a small accumulator processor that keeps code and data in one read/write memory. Every instruction is two consecutive words. The first word carries a 3-bit operation code in its low bits. The second word is an address field. The core walks through fetch, execute and, when it needs one, an operand read, using a single-port synchronous memory bus. A read returns data on the cycle after the address is presented, and a write takes effect on the clock edge where write enable is high.

The accumulator can be combined with a memory operand, loaded from memory, complemented or written back to memory. A zero-test branch adds the address field to the current program counter. Because stores can land anywhere, a program can overwrite code that it runs later. The reset input is asserted asynchronously and released through an internal synchronizer.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, mem_addr_o is 0 and mem_we_o is 0. Reset clears the program counter and the accumulator to 0. After rst_ni rises, the first fetch cycle is the one that follows the second rising edge.
- R2: An instruction begins with one cycle presenting PC, then one cycle presenting PC+1 (mod 256). The opcode is bits [2:0] of the word at PC, and bits [7:3] of that word have no effect. The address field is the whole word at PC+1.
- R3: Opcode 2 ANDs, opcode 3 ORs and opcode 4 adds the word at the address field into the accumulator. The sum wraps modulo 256.
- R4: Opcode 5 loads the accumulator with the word at the address field.
- R5: Opcode 6 raises mem_we_o for exactly one cycle, with mem_addr_o equal to the address field and mem_wdata_o equal to the accumulator.
- R6: Opcode 0 changes nothing except the program counter. Opcode 1 replaces the accumulator with its bitwise complement.
- R7: Opcode 7 leaves the accumulator unchanged. If the accumulator is zero, the PC becomes PC plus the address field, modulo 256. Otherwise the PC becomes PC+2.
- R8: Every opcode other than 7 advances the PC by 2, modulo 256.
- R9: Opcodes 0, 1, 6 and 7 take 4 cycles and opcodes 2 to 5 take 5. The third cycle has write enable low. The fourth cycle presents the address field. For opcodes 2 to 5, the fifth cycle presents the address field again with write enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 8 | Memory write data (the accumulator) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after its address |

## Verification
The hardest case to reach from the ports is a taken zero-test branch whose target wraps past the top of the address space. It needs a zero accumulator at exactly the right instruction, and random code rarely produces one. The directed program sets up a zero accumulator on purpose and then branches backwards through the wrap. The random programs fill memory with a heavy share of zero words, so AND and load results are often zero, branches are often taken, and random stores often overwrite code that runs later. A cycle-by-cycle bench model of the bus follows every instruction of both.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Opcode width is fixed by the instruction format.
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_INV = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_ADD = 3'd4,
    OP_LDM = 3'd5,
    OP_STM = 3'd6,
    OP_BZR = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_ADDR_OP  = 3'd0,   // present PC
    ST_TAKE_OP  = 3'd1,   // capture opcode, present PC+1
    ST_TAKE_FLD = 3'd2,   // capture address field
    ST_EXEC     = 3'd3,   // present field; store, branch or single-cycle op
    ST_RDBK     = 3'd4    // operand returned, update accumulator
  } state_e;

  function automatic logic op_reads(input op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) || (op == OP_LDM);
  endfunction

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  generate
    if (STAGES < 2) begin : g_single
      logic sh_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sh_q <= 1'b0;
        else          sh_q <= 1'b1;
      end
      assign srst_no = sh_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sh_q <= '0;
        else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
      assign srst_no = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/acc_cpu_accu.sv
module acc_cpu_accu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              acc_zero_o
);

  logic [DATA_W-1:0] acc_q, acc_d;

  // Result selection
  always_comb begin
    unique case (op_i)
      OP_INV:  acc_d = ~acc_q;
      OP_AND:  acc_d = acc_q & opnd_i;
      OP_OR:   acc_d = acc_q | opnd_i;
      OP_ADD:  acc_d = acc_q + opnd_i;
      OP_LDM:  acc_d = opnd_i;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (acc_en_i) acc_q <= acc_d;
  end

  assign acc_o      = acc_q;
  assign acc_zero_o = (acc_q == '0);

  // R3
  add_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && op_i == OP_ADD) |=> (acc_q == DATA_W'($past(acc_q) + $past(opnd_i))));

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] word_i,
  input  logic              acc_zero_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              acc_en_o,
  output op_e               op_o
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PC_WORD = ADDR_W'(1);

  state_e            st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_seq, pc_rel;
  logic              pc_en;
  op_e               op_q, op_d;
  logic              op_en;
  logic [ADDR_W-1:0] fld_q;
  logic              fld_en;

  assign pc_seq = pc_q + PC_STEP;
  assign pc_rel = pc_q + fld_q;
  assign op_d   = op_e'(word_i[OP_W-1:0]);

  // Next state and bus drive
  always_comb begin
    st_d       = st_q;
    pc_d       = pc_seq;
    pc_en      = 1'b0;
    op_en      = 1'b0;
    fld_en     = 1'b0;
    acc_en_o   = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = pc_q;
    unique case (st_q)
      ST_ADDR_OP: begin
        st_d = ST_TAKE_OP;
      end
      ST_TAKE_OP: begin
        op_en      = 1'b1;
        mem_addr_o = pc_q + PC_WORD;
        st_d       = ST_TAKE_FLD;
      end
      ST_TAKE_FLD: begin
        fld_en     = 1'b1;
        mem_addr_o = pc_q + PC_WORD;
        st_d       = ST_EXEC;
      end
      ST_EXEC: begin
        mem_addr_o = fld_q;
        if (op_reads(op_q)) begin
          st_d = ST_RDBK;
        end else begin
          st_d     = ST_ADDR_OP;
          pc_en    = 1'b1;
          mem_we_o = (op_q == OP_STM);
          acc_en_o = (op_q == OP_INV);
          if (op_q == OP_BZR && acc_zero_i) pc_d = pc_rel;
        end
      end
      ST_RDBK: begin
        mem_addr_o = fld_q;
        acc_en_o   = 1'b1;
        pc_en      = 1'b1;
        st_d       = ST_ADDR_OP;
      end
      default: begin
        st_d = ST_ADDR_OP;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ADDR_OP;
      pc_q  <= '0;
      op_q  <= OP_NOP;
      fld_q <= '0;
    end else begin
      st_q <= st_d;
      if (pc_en)  pc_q  <= pc_d;
      if (op_en)  op_q  <= op_d;
      if (fld_en) fld_q <= word_i;
    end
  end

  assign op_o = op_q;

  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R8
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_q) |-> ((pc_q == ADDR_W'($past(pc_q) + PC_STEP)) || ($past(op_q) == OP_BZR)));

  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXEC && op_q == OP_BZR) |=> $stable(acc_i));

  // R2
  fetch_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAKE_OP) |-> ($past(mem_addr_o) == pc_q));

  // R9
  rd_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RDBK) |-> (($past(st_q) == ST_EXEC) && ($past(mem_addr_o) == mem_addr_o)));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 8,  // must not exceed DATA_W
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic              rst_sn;
  logic              acc_en;
  logic              acc_zero;
  logic [DATA_W-1:0] acc;
  op_e               op;

  acc_cpu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_sn)
  );

  acc_cpu_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .word_i     (mem_rdata_i[ADDR_W-1:0]),
    .acc_zero_i (acc_zero),
    .acc_i      (acc),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .acc_en_o   (acc_en),
    .op_o       (op)
  );

  acc_cpu_accu #(.DATA_W(DATA_W)) u_accu (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .acc_en_i   (acc_en),
    .op_i       (op),
    .opnd_i     (mem_rdata_i),
    .acc_o      (acc),
    .acc_zero_o (acc_zero)
  );

  assign mem_wdata_o = acc;

endmodule

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr, wdata, rdata;
  logic       we;

  logic [7:0] ram [256];
  logic [7:0] m   [256];
  logic [7:0] macc, mpc;

  int total = 0, bad = 0, cyc = 0, cyc_run = 0;
  bit done = 1'b0;
  logic [7:0] obs_pc [64];
  logic [7:0] st_a [64], st_d [64];
  int n_pc, n_st;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end

  acc_cpu dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .mem_rdata_i (rdata)
  );

  function automatic logic [7:0] f_alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    case (op)
      3'd1: return ~a;
      3'd2: return a & d;
      3'd3: return a | d;
      3'd4: return 8'(a + d);
      3'd5: return d;
      default: return a;
    endcase
  endfunction

  function automatic bit f_reads(input logic [2:0] op);
    return (op >= 3'd2) && (op <= 3'd5);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(addr == 8'h00 && !we, "R1 bus idle in reset", {addr, 7'd0, we}, 0);
    end
    for (int i = 0; i < 256; i++) m[i] = ram[i];
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    macc = 8'h00; mpc = 8'h00; n_pc = 0; n_st = 0; cyc_run = 0;
  endtask

  // Cycle-accurate bus model, one instruction per iteration
  task automatic run_instr(input int n);
    for (int i = 0; i < n; i++) begin
      logic [2:0] op;
      logic [7:0] fa, f, pc1;
      pc1 = 8'(mpc + 8'd1);
      op  = m[mpc][2:0];
      f   = m[pc1];
      @(negedge clk);
      chk(addr == mpc && !we, "R2 opcode fetch address", addr, mpc);
      if (n_pc < 64) begin obs_pc[n_pc] = addr; n_pc++; end
      @(negedge clk);
      chk(addr == pc1 && !we, "R2 field fetch address", addr, pc1);
      @(negedge clk);
      chk(!we, "R9 third cycle write low", we, 0);
      @(negedge clk);
      chk(addr == f && we == (op == 3'd6), "R9 exec cycle address/we", {addr, 7'd0, we}, {f, 7'd0, op == 3'd6});
      if (op == 3'd6) begin
        chk(wdata == macc, "R5 store data", wdata, macc);
        if (n_st < 64) begin st_a[n_st] = addr; st_d[n_st] = wdata; n_st++; end
        m[f] = macc;
      end
      cyc_run += 4;
      if (f_reads(op)) begin
        @(negedge clk);
        chk(addr == f && !we, "R9 operand cycle", {addr, 7'd0, we}, {f, 8'd0});
        macc = f_alu(op, macc, m[f]);
        cyc_run += 1;
      end else begin
        macc = f_alu(op, macc, 8'h00);
      end
      fa  = (op == 3'd7 && macc == 8'h00) ? f : 8'd2;
      mpc = 8'(mpc + fa);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] op, input logic [7:0] f);
    ram[a] = op; ram[8'(a + 8'd1)] = f;
  endtask

  initial begin : main
    logic [7:0] exp_pc [19];
    logic [7:0] exp_sa [7];
    logic [7:0] exp_sd [7];
    void'($urandom(32'd24681));
    exp_pc = '{8'd0, 8'd2, 8'd4, 8'd6, 8'd8, 8'd10, 8'd12, 8'd18, 8'd20, 8'd22,
               8'd24, 8'd26, 8'd28, 8'd30, 8'd32, 8'd34, 8'd36, 8'd4, 8'd6};
    exp_sa = '{8'hA0, 8'hA1, 8'hA2, 8'hA4, 8'hA5, 8'hA6, 8'hA1};
    exp_sd = '{8'hF0, 8'hFF, 8'h00, 8'h01, 8'h01, 8'h01, 8'h0F};

    // Directed program
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    ram[8'h80] = 8'hF0; ram[8'h81] = 8'h0F; ram[8'h82] = 8'h02;
    ram[8'h83] = 8'h03; ram[8'h84] = 8'h00; ram[8'hA3] = 8'h55;
    put(8'd0,  8'h05, 8'h80);  // load F0
    put(8'd2,  8'h06, 8'hA0);
    put(8'd4,  8'h03, 8'h81);  // or
    put(8'd6,  8'h06, 8'hA1);
    put(8'd8,  8'h01, 8'h00);  // complement
    put(8'd10, 8'h06, 8'hA2);
    put(8'd12, 8'h07, 8'h06);  // taken to 18
    put(8'd14, 8'h06, 8'hA3);  // skipped
    put(8'd18, 8'hF9, 8'h00);  // complement, upper opcode bits set
    put(8'd20, 8'h04, 8'h82);  // FF+02 wraps to 01
    put(8'd22, 8'h06, 8'hA4);
    put(8'd24, 8'h07, 8'h40);  // not taken
    put(8'd26, 8'h02, 8'h83);  // and
    put(8'd28, 8'h06, 8'hA5);
    put(8'd30, 8'h00, 8'h77);  // nop
    put(8'd32, 8'h06, 8'hA6);
    put(8'd34, 8'h05, 8'h84);  // load 00
    put(8'd36, 8'h07, 8'hE0);  // taken, 36+224 wraps to 4
    do_reset();
    run_instr(19);
    for (int i = 0; i < 19; i++)
      chk(obs_pc[i] == exp_pc[i], "R7/R8 directed PC sequence (R7 R8)", obs_pc[i], exp_pc[i]);
    chk(n_st == 7, "R5 directed store count", n_st, 7);
    for (int i = 0; i < 7; i++) begin
      chk(st_a[i] == exp_sa[i], "R5 directed store address", st_a[i], exp_sa[i]);
      chk(st_d[i] == exp_sd[i], "R3/R4/R6 directed store data (R3 R4 R6 R2)", st_d[i], exp_sd[i]);
    end
    chk(ram[8'hA3] == 8'h55, "R7 skipped store left memory alone", ram[8'hA3], 8'h55);
    chk(cyc_run == 82, "R9 directed cycle count", cyc_run, 82);

    // Reset clears accumulator: first instruction stores it
    put(8'd0, 8'h06, 8'hB0);
    ram[8'hB0] = 8'hAA;
    do_reset();
    run_instr(1);
    @(negedge clk);
    chk(ram[8'hB0] == 8'h00, "R1 accumulator cleared by reset", ram[8'hB0], 0);

    // Random programs with many zero words
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 256; i++)
        ram[i] = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      do_reset();
      run_instr(300);
      for (int i = 0; i < 256; i++)
        chk(ram[i] == m[i], "R3 R5 random final memory image", ram[i], m[i]);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R9 watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule